// File: doc/BRIEF.md
# Configurable Eight-Pin I/O Port

This block controls eight bidirectional pad signals. Each pin is set up on its own as a general-purpose input, a general-purpose output, or a special-function pin. A special-function pin is handed to one of three serial engines that sit outside the block: a synchronous serial master (SPI), a two-wire bus controller (I2C) or an asynchronous serial transceiver (UART). The pad-facing side gives each pin a data value and an output enable. The engine-facing side is a set of plain signal bundles.

Software sets the port up through a small register bus. One register holds a 2-bit mode per pin. Two registers hold a 3-bit function code per pin, which picks the serial signal that a special-function pin carries. One register holds the general-purpose output values. A read-only register shows the synchronised pad levels. The two-wire signals use open-drain behaviour: the pin is only ever driven low, and it is released to let the bus float high.

Pad levels pass through a two-stage synchroniser. That synchronised view feeds both the input data register and the engine-side receive signals. Reads are combinational: `bus_rdata` carries the addressed register while `bus_sel` is high, and is zero otherwise. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high.

Top module: `cfg_io_port`

## Requirements
- R1: After a synchronous reset, every `pad_oe` and `pad_out` bit is 0, and the mode (address 0), function (addresses 1 and 2) and output-data (address 3) registers read 0.
- R2: A pin whose 2-bit mode field (mode register bits [2i+1:2i] for pin i) is 00 (input) or 11 (reserved) has `pad_oe` = 0 and `pad_out` = 0.
- R3: A pin in mode 01 (output) has `pad_oe` = 1, and its `pad_out` equals bit i of the output-data register.
- R4: A pin in mode 10 (special) with function code 0 (clock), 1 (master-out data), 3 (slave select) or 6 (serial transmit) has `pad_oe` = 1, and its `pad_out` equals `sf_sck`, `sf_mosi`, `sf_ss` or `sf_tx` respectively.
- R5: A pin in mode 10 with function code 2 (master-in data) or 7 (serial receive) has `pad_oe` = 0 and `pad_out` = 0.
- R6: A pin in mode 10 with function code 4 (two-wire data) or 5 (two-wire clock) behaves as open-drain: `pad_out` is always 0, and `pad_oe` equals `sf_sda_low` or `sf_scl_low` respectively.
- R7: Each engine receive signal (`sf_miso` for code 2, `sf_sda_in` for 4, `sf_scl_in` for 5, `sf_rx` for 7) carries the synchronised level of the lowest-numbered pin in mode 10 with that code, two clock edges after the pad changes. It is 1 when no pin has that mode and code.
- R8: The input-data register (address 4, bits [7:0]) shows the pad levels after exactly two clock edges. Writes to it have no effect.
- R9: Function codes sit in 4-bit slots: address 1 bits [4k+2:4k] belong to pin k, and address 2 bits [4k+2:4k] belong to pin 4+k. The top bit of each slot reads 0. The output-data register keeps bits [7:0] only. Addresses 5 to 7 read 0, and writes to them change nothing.
- R10: Each pin's behaviour depends only on its own mode and function fields. Pins that are not configured stay released while a neighbour is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | BUS_AW | Register address |
| bus_wdata | input | BUS_DW | Write data |
| bus_rdata | output | BUS_DW | Read data (combinational, zero when not selected) |
| pad_in | input | 8 | Pad levels seen at the pins |
| pad_out | output | 8 | Value driven on each pin |
| pad_oe | output | 8 | Output enable for each pin |
| sf_sck | input | 1 | Serial master clock from the SPI engine |
| sf_mosi | input | 1 | Serial master output data |
| sf_ss | input | 1 | Serial slave select |
| sf_tx | input | 1 | Asynchronous transmit data |
| sf_sda_low | input | 1 | Two-wire engine requests data line low |
| sf_scl_low | input | 1 | Two-wire engine requests clock line low |
| sf_miso | output | 1 | Serial master input data to the SPI engine |
| sf_sda_in | output | 1 | Two-wire data line level |
| sf_scl_in | output | 1 | Two-wire clock line level |
| sf_rx | output | 1 | Asynchronous receive data |

## Verification
The pad mux is swept over every pin, every mode and every function code. For each setting, all 64 combinations of the six engine drive signals are applied, so a swapped engine signal, an open-drain pin that drives high, or a leak onto a neighbouring pin each give a distinct mismatch. The receive path is run with all 256 pad patterns on a port where two pins share a code, which separates lowest-index priority from other choices. It is also run with no pin selected, which exposes the idle value. Single-step pad transitions tell a two-edge synchroniser apart from one with a stage too few. Register writes with all-ones data and writes to unmapped addresses expose slot masking and decode faults.

// File: rtl/cfgio_pkg.sv
package cfgio_pkg;
  localparam int PIN_N     = 8;
  localparam int MODE_W    = 2;
  localparam int FSEL_W    = 3;
  localparam int FSEL_SLOT = 4;

  typedef enum logic [1:0] {
    PM_IN  = 2'b00,
    PM_OUT = 2'b01,
    PM_ALT = 2'b10,
    PM_RSV = 2'b11
  } pin_mode_e;

  typedef enum logic [2:0] {
    AF_SCK  = 3'd0,
    AF_MOSI = 3'd1,
    AF_MISO = 3'd2,
    AF_SS   = 3'd3,
    AF_SDA  = 3'd4,
    AF_SCL  = 3'd5,
    AF_TX   = 3'd6,
    AF_RX   = 3'd7
  } alt_fn_e;

  typedef struct packed {
    logic sck;
    logic mosi;
    logic ss;
    logic tx;
    logic sda_low;
    logic scl_low;
  } alt_drive_t;

  localparam logic [2:0] RA_MODE    = 3'd0;
  localparam logic [2:0] RA_FSEL_LO = 3'd1;
  localparam logic [2:0] RA_FSEL_HI = 3'd2;
  localparam logic [2:0] RA_ODATA   = 3'd3;
  localparam logic [2:0] RA_IDATA   = 3'd4;

  // push-pull special functions
  function automatic logic fn_drives(input alt_fn_e f);
    return (f == AF_SCK) || (f == AF_MOSI) || (f == AF_SS) || (f == AF_TX);
  endfunction

  // two-wire functions, released high / pulled low only
  function automatic logic fn_open_drain(input alt_fn_e f);
    return (f == AF_SDA) || (f == AF_SCL);
  endfunction

  // level of the lowest-indexed hit; idle-high when nothing hits
  function automatic logic first_hit(input logic [PIN_N-1:0] hit,
                                     input logic [PIN_N-1:0] lvl);
    logic r;
    r = 1'b1;
    for (int i = PIN_N - 1; i >= 0; i--) begin
      if (hit[i]) r = lvl[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/io_in_sync.sv
module io_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];
  logic         warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
      warm <= 1'b0;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
      warm <= 1'b1;
    end
  end

  assign q = stage[STAGES-1];

  // R8: first stage captures the pad one edge later
  a_r8_sync_capture: assert property (@(posedge clk) disable iff (rst)
    warm |-> (stage[0] == $past(d)));

  for (genvar s = 1; s < STAGES; s++) begin : g_shift_chk
    // R8: each later stage is the previous stage delayed by one edge
    a_r8_sync_shift: assert property (@(posedge clk) disable iff (rst)
      warm |-> (stage[s] == $past(stage[s-1])));
  end
endmodule

// File: rtl/io_pin_cell.sv
module io_pin_cell
  import cfgio_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [FSEL_W-1:0] fsel,
  input  logic              out_bit,
  input  alt_drive_t        drv,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              alt_on
);
  alt_fn_e fn;
  logic    alt_val;

  always_comb begin
    fn     = alt_fn_e'(fsel);
    alt_on = (pin_mode_e'(mode) == PM_ALT);
    case (fn)
      AF_SCK:  alt_val = drv.sck;
      AF_MOSI: alt_val = drv.mosi;
      AF_SS:   alt_val = drv.ss;
      AF_TX:   alt_val = drv.tx;
      default: alt_val = 1'b0;
    endcase
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    case (pin_mode_e'(mode))
      PM_OUT: begin
        pad_out = out_bit;
        pad_oe  = 1'b1;
      end
      PM_ALT: begin
        if (fn_drives(fn)) begin
          pad_out = alt_val;
          pad_oe  = 1'b1;
        end else if (fn_open_drain(fn)) begin
          pad_oe = (fn == AF_SDA) ? drv.sda_low : drv.scl_low;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/io_port_regs.sv
module io_port_regs
  import cfgio_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sel,
  input  logic                     wr,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  input  logic [PIN_N-1:0]         idata,
  output logic [DW-1:0]            rdata,
  output logic [MODE_W*PIN_N-1:0]  mode_vec,
  output logic [FSEL_W*PIN_N-1:0]  fsel_vec,
  output logic [PIN_N-1:0]         odata
);
  localparam int FS_PER_REG = DW / FSEL_SLOT;
  localparam int MODE_BITS  = MODE_W * PIN_N;

  logic [MODE_BITS-1:0]    mode_q;
  logic [FSEL_W*PIN_N-1:0] fsel_q;
  logic [PIN_N-1:0]        odata_q;
  logic                    wen;

  assign wen = sel && wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      fsel_q  <= '0;
      odata_q <= '0;
    end else if (wen) begin
      case (addr)
        AW'(RA_MODE):    mode_q <= wdata[MODE_BITS-1:0];
        AW'(RA_FSEL_LO):
          for (int k = 0; k < FS_PER_REG; k++)
            fsel_q[FSEL_W*k +: FSEL_W] <= wdata[FSEL_SLOT*k +: FSEL_W];
        AW'(RA_FSEL_HI):
          for (int k = 0; k < FS_PER_REG; k++)
            fsel_q[FSEL_W*(k+FS_PER_REG) +: FSEL_W] <= wdata[FSEL_SLOT*k +: FSEL_W];
        AW'(RA_ODATA):   odata_q <= wdata[PIN_N-1:0];
        default: ;
      endcase
    end
  end

  // spreads packed 3-bit codes into 4-bit slots for readback
  function automatic logic [DW-1:0] pack_fsel(input logic [FSEL_W*PIN_N-1:0] v,
                                              input int base);
    logic [DW-1:0] r;
    r = '0;
    for (int k = 0; k < FS_PER_REG; k++)
      r[FSEL_SLOT*k +: FSEL_W] = v[FSEL_W*(base+k) +: FSEL_W];
    return r;
  endfunction

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (addr)
        AW'(RA_MODE):    rdata = DW'(mode_q);
        AW'(RA_FSEL_LO): rdata = pack_fsel(fsel_q, 0);
        AW'(RA_FSEL_HI): rdata = pack_fsel(fsel_q, FS_PER_REG);
        AW'(RA_ODATA):   rdata = DW'(odata_q);
        AW'(RA_IDATA):   rdata = DW'(idata);
        default:         rdata = '0;
      endcase
    end
  end

  assign mode_vec = mode_q;
  assign fsel_vec = fsel_q;
  assign odata    = odata_q;

  // R9: mode holds unless its own address is written
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !(wen && addr == AW'(RA_MODE)) |=> $stable(mode_q));

  // R9: output data holds unless its own address is written
  a_r9_odata_hold: assert property (@(posedge clk) disable iff (rst)
    !(wen && addr == AW'(RA_ODATA)) |=> $stable(odata_q));

  // R9: function codes hold unless one of the two select addresses is written
  a_r9_fsel_hold: assert property (@(posedge clk) disable iff (rst)
    !(wen && (addr == AW'(RA_FSEL_LO) || addr == AW'(RA_FSEL_HI))) |=> $stable(fsel_q));
endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
  import cfgio_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BUS_AW      = 3,
  parameter int BUS_DW      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [7:0]        pad_in,
  output logic [7:0]        pad_out,
  output logic [7:0]        pad_oe,
  input  logic              sf_sck,
  input  logic              sf_mosi,
  input  logic              sf_ss,
  input  logic              sf_tx,
  input  logic              sf_sda_low,
  input  logic              sf_scl_low,
  output logic              sf_miso,
  output logic              sf_sda_in,
  output logic              sf_scl_in,
  output logic              sf_rx
);
  logic [MODE_W*PIN_N-1:0] mode_vec;
  logic [FSEL_W*PIN_N-1:0] fsel_vec;
  logic [PIN_N-1:0]        odata;
  logic [PIN_N-1:0]        idata;
  logic [PIN_N-1:0]        pin_alt;
  logic [PIN_N-1:0]        hit_miso, hit_sda, hit_scl, hit_rx;
  alt_drive_t              drv;

  assign drv = '{sck: sf_sck, mosi: sf_mosi, ss: sf_ss, tx: sf_tx,
                 sda_low: sf_sda_low, scl_low: sf_scl_low};

  io_port_regs #(.AW(BUS_AW), .DW(BUS_DW)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .idata(idata), .rdata(bus_rdata),
    .mode_vec(mode_vec), .fsel_vec(fsel_vec), .odata(odata));

  io_in_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(idata));

  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    logic [FSEL_W-1:0] code;
    assign code = fsel_vec[FSEL_W*i +: FSEL_W];

    io_pin_cell u_pin (
      .mode(mode_vec[MODE_W*i +: MODE_W]), .fsel(code), .out_bit(odata[i]),
      .drv(drv), .pad_out(pad_out[i]), .pad_oe(pad_oe[i]), .alt_on(pin_alt[i]));

    assign hit_miso[i] = pin_alt[i] && (code == AF_MISO);
    assign hit_sda[i]  = pin_alt[i] && (code == AF_SDA);
    assign hit_scl[i]  = pin_alt[i] && (code == AF_SCL);
    assign hit_rx[i]   = pin_alt[i] && (code == AF_RX);

    // R2: input and reserved modes leave the pin released
    a_r2_input_released: assert property (@(posedge clk) disable iff (rst)
      (mode_vec[MODE_W*i +: MODE_W] == PM_IN || mode_vec[MODE_W*i +: MODE_W] == PM_RSV)
        |-> (!pad_oe[i] && !pad_out[i]));

    // R5: receive-only functions never drive
    a_r5_receive_released: assert property (@(posedge clk) disable iff (rst)
      (hit_miso[i] || hit_rx[i]) |-> !pad_oe[i]);

    // R6: two-wire pins never drive a high level
    a_r6_open_drain_low: assert property (@(posedge clk) disable iff (rst)
      (hit_sda[i] || hit_scl[i]) |-> !pad_out[i]);
  end

  assign sf_miso   = first_hit(hit_miso, idata);
  assign sf_sda_in = first_hit(hit_sda,  idata);
  assign sf_scl_in = first_hit(hit_scl,  idata);
  assign sf_rx     = first_hit(hit_rx,   idata);

  // R1: one reset edge leaves every pin released
  a_r1_reset_release: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0));

  // R7: an unclaimed receive line idles high
  a_r7_idle_high: assert property (@(posedge clk) disable iff (rst)
    (hit_miso == '0) |-> sf_miso);

  // R7: lowest claimed pin's synchronised level reaches the engine
  a_r7_rx_from_pin0: assert property (@(posedge clk) disable iff (rst)
    hit_rx[0] |-> (sf_rx == idata[0]));
endmodule

// File: tb/cfg_io_port_tb.sv
module cfg_io_port_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [7:0]  pad_in, pad_out, pad_oe;
  logic [5:0]  eng;
  logic        sf_miso, sf_sda_in, sf_scl_in, sf_rx;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_io_port u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe),
    .sf_sck(eng[0]), .sf_mosi(eng[1]), .sf_ss(eng[2]), .sf_tx(eng[3]),
    .sf_sda_low(eng[4]), .sf_scl_low(eng[5]),
    .sf_miso(sf_miso), .sf_sda_in(sf_sda_in), .sf_scl_in(sf_scl_in), .sf_rx(sf_rx));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  // expected drive of one pin, written as a table over the encodings
  task automatic model(input int m, input int f, input logic [5:0] e, input logic ob,
                       output logic oe, output logic o);
    oe = 0; o = 0;
    if (m == 1) begin oe = 1; o = ob; end
    else if (m == 2) begin
      if (f == 0)      begin oe = 1; o = e[0]; end
      else if (f == 1) begin oe = 1; o = e[1]; end
      else if (f == 3) begin oe = 1; o = e[2]; end
      else if (f == 6) begin oe = 1; o = e[3]; end
      else if (f == 4) oe = e[4];
      else if (f == 5) oe = e[5];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic eoe, eo;
    rst = 1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    pad_in = 8'h00; eng = 6'h3F;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    #1;
    check("R1 oe", 32'(pad_oe), 0);
    check("R1 out", 32'(pad_out), 0);
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), r);
      check("R1 reg", 32'(r), 0);
    end

    // R2 R3 R4 R5 R6 R10: sweep pin x mode x code x engine levels
    for (int p = 0; p < 8; p++)
      for (int m = 0; m < 4; m++)
        for (int f = 0; f < 8; f++) begin
          logic [7:0] od;
          od = 8'(p * 29 + m * 7 + f * 3 + 1);
          wr(3'd0, 16'(m) << (2 * p));
          wr(3'd1, (p < 4) ? (16'(f) << (4 * p)) : 16'h0);
          wr(3'd2, (p >= 4) ? (16'(f) << (4 * (p - 4))) : 16'h0);
          wr(3'd3, 16'(od));
          for (int e = 0; e < 64; e++) begin
            logic [7:0] xoe, xo;
            eng = 6'(e);
            #1;
            model(m, f, 6'(e), od[p], eoe, eo);
            xoe = 8'(eoe) << p;
            xo  = 8'(eo) << p;
            check("R2-R6/R10 oe", 32'(pad_oe), 32'(xoe));
            check("R2-R6/R10 out", 32'(pad_out), 32'(xo));
          end
        end

    // R9: register map and slot masking
    wr(3'd0, 16'h1234); rd(3'd0, r); check("R9 mode", 32'(r), 32'h1234);
    wr(3'd1, 16'hFFFF); rd(3'd1, r); check("R9 fsel lo", 32'(r), 32'h7777);
    wr(3'd2, 16'h8888); rd(3'd2, r); check("R9 fsel hi", 32'(r), 32'h0000);
    wr(3'd3, 16'hABCD); rd(3'd3, r); check("R9 odata", 32'(r), 32'h00CD);
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 16'hFFFF);
      rd(3'(a), r); check("R9 unmapped read", 32'(r), 0);
    end
    rd(3'd0, r); check("R9 mode after unmapped", 32'(r), 32'h1234);
    rd(3'd1, r); check("R9 fsel after unmapped", 32'(r), 32'h7777);
    rd(3'd3, r); check("R9 odata after unmapped", 32'(r), 32'h00CD);

    // R8: input data register follows pads, two-edge latency, read-only
    wr(3'd0, 16'h0000);
    for (int v = 0; v < 256; v++) begin
      logic [7:0] prev;
      prev = pad_in;
      pad_in = 8'(v * 37 + 5);
      @(negedge clk); rd(3'd4, r); check("R8 one edge", 32'(r), 32'(prev));
      @(negedge clk); rd(3'd4, r); check("R8 two edges", 32'(r), 32'(pad_in));
    end
    wr(3'd4, 16'h00FF ^ 16'(pad_in));
    rd(3'd4, r); check("R8 write ignored", 32'(r), 32'(pad_in));

    // R7: receive routing with shared code and lowest-index priority
    wr(3'd0, 16'hAAAA);
    wr(3'd1, 16'h0427);
    wr(3'd2, 16'h0502);
    eng = 6'h00;
    for (int v = 0; v < 256; v++) begin
      pad_in = 8'(v);
      @(negedge clk); @(negedge clk); #1;
      check("R7 miso lowest", 32'(sf_miso), 32'(pad_in[1]));
      check("R7 sda", 32'(sf_sda_in), 32'(pad_in[2]));
      check("R7 scl", 32'(sf_scl_in), 32'(pad_in[6]));
      check("R7 rx", 32'(sf_rx), 32'(pad_in[0]));
    end
    // R7: pin1 back to input, pin4 now the only master-in source
    wr(3'd0, 16'hAAA2);
    pad_in = 8'h10;
    @(negedge clk); @(negedge clk); #1;
    check("R7 miso from pin4", 32'(sf_miso), 1);
    pad_in = 8'hEF;
    @(negedge clk); #1;
    check("R7 miso latency", 32'(sf_miso), 1);
    @(negedge clk); #1;
    check("R7 miso pin4 low", 32'(sf_miso), 0);
    // R7: nothing claimed, all receive lines idle high
    wr(3'd0, 16'h0000);
    pad_in = 8'h00;
    @(negedge clk); @(negedge clk); #1;
    check("R7 idle miso", 32'(sf_miso), 1);
    check("R7 idle sda", 32'(sf_sda_in), 1);
    check("R7 idle scl", 32'(sf_scl_in), 1);
    check("R7 idle rx", 32'(sf_rx), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule